// File: doc/BRIEF.md
# Six-Requester Memory Ownership Arbiter

This block decides which of six requesters owns the memory bus in front of a DRAM controller. Each requester raises its own request line. When the bus is free, the arbiter picks the most urgent pending request and grants it through a one-hot, registered grant vector. The owner keeps the bus for its whole transaction and gives it up by pulsing its `done` line. Only after that release does the arbiter pick again. Address, data and command forwarding are handled elsewhere. This block decides ownership only.

The six slots follow a fixed urgency ladder. An urgent refresh comes first, then an urgent graphics-port access, then a processor read, then a processor write, then a relaxed graphics-port access. A relaxed refresh comes last. Refresh therefore appears at both ends of the ladder: it wins when it cannot wait any longer, and it yields to all other traffic when it can. The arbiter remembers no request. A line that drops before it is granted leaves no trace.

All pins are plain control pins with no data stream, so there is no valid/ready handshake and no back-pressure. The `busy` output tells the controller that some requester owns the bus.

Top module: `mem_owner_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `gnt` is all zeros and `busy` is low.
- R2: At most one bit of `gnt` is ever set.
- R3: Suppose the arbiter is idle (`gnt` zero) at a rising clock edge and at least one `req` bit is set. After that edge, `gnt` has exactly one bit set: the lowest-numbered requesting bit. The bit numbering is:
  - bit 0: urgent refresh
  - bit 1: urgent graphics access
  - bit 2: processor read
  - bit 3: processor write
  - bit 4: relaxed graphics access
  - bit 5: relaxed refresh
- R4: While the owner's `done` bit is low, `gnt` keeps its value from edge to edge. This holds whatever `req` does, including requests of higher priority and the owner dropping its own request.
- R5: A rising edge at which the owner's `done` bit is high clears `gnt` and `busy` after that edge.
- R6: `done` bits belonging to requesters that do not own the bus have no effect on `gnt`.
- R7: After a release, a request that is still pending is granted at the next edge. The bus is therefore free for exactly one cycle between two owners.
- R8: When the arbiter is idle and no `req` bit is set at an edge, it stays idle.
- R9: `busy` is high exactly when some bit of `gnt` is set.
- R10: A request raised and withdrawn while another requester owns the bus is never granted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | Request line per requester, bit order as in R3 |
| done | input | 6 | End-of-transaction pulse per requester; only the owner's bit counts |
| gnt | output | 6 | Registered one-hot grant |
| busy | output | 1 | Registered; high while some requester owns the bus |

## Verification
The bench raises higher-priority requests while another requester owns the bus. A design that lets them preempt would switch `gnt` mid-transaction. It drives `done` on non-owners, which a design that ORs all `done` bits would treat as a release. It pulses a request during ownership and then withdraws it, to catch a design that latches requests and grants a ghost after the release. It also measures the gap between two owners: a design that re-arbitrates in the release cycle gives no gap and never drops `busy`, and a design that waits an extra cycle gives a two-cycle gap.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_MASTERS = 6;

  typedef enum int {
    SLOT_RFSH_URGENT = 0,
    SLOT_GFX_URGENT  = 1,
    SLOT_CPU_RD      = 2,
    SLOT_CPU_WR      = 3,
    SLOT_GFX_RELAX   = 4,
    SLOT_RFSH_RELAX  = 5
  } slot_e;
endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: index 0 wins. Pure combinational ripple chain.
module arb_prio_pick #(
  parameter int N = arb_pkg::NUM_MASTERS
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign pick[i]   = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/arb_release_detect.sv
// Flags when the current owner signals the end of its transaction.
module arb_release_detect #(
  parameter int N = arb_pkg::NUM_MASTERS
) (
  input  logic [N-1:0] owner,
  input  logic [N-1:0] done,
  output logic         owner_done
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = owner[i] & done[i];
  end
  assign owner_done = |hit;
endmodule

// File: rtl/arb_owner_hold.sv
// Holds the registered grant: idle -> pick, owned -> hold until release.
module arb_owner_hold #(
  parameter int N = arb_pkg::NUM_MASTERS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pick,
  input  logic         owner_done,
  output logic [N-1:0] owner,
  output logic         busy
);
  logic [N-1:0] owner_d;
  logic         idle;

  assign idle = (owner == '0);

  always_comb begin
    if (idle)            owner_d = pick;
    else if (owner_done) owner_d = '0;
    else                 owner_d = owner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= '0;
      busy  <= 1'b0;
    end else begin
      owner <= owner_d;
      busy  <= |owner_d;
    end
  end
endmodule

// File: rtl/mem_owner_arbiter.sv
module mem_owner_arbiter #(
  parameter int N = arb_pkg::NUM_MASTERS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] gnt,
  output logic         busy
);
  logic [N-1:0] pick;
  logic         owner_done;

  arb_prio_pick #(.N(N)) u_pick (
    .req  (req),
    .pick (pick)
  );

  arb_release_detect #(.N(N)) u_rel (
    .owner      (gnt),
    .done       (done),
    .owner_done (owner_done)
  );

  arb_owner_hold #(.N(N)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick       (pick),
    .owner_done (owner_done),
    .owner      (gnt),
    .busy       (busy)
  );
endmodule

// File: rtl/mem_owner_arbiter_chk.sv
module mem_owner_arbiter_chk #(
  parameter int N = arb_pkg::NUM_MASTERS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] done,
  input logic [N-1:0] gnt,
  input logic         busy
);
  // R1
  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (gnt == '0 && !busy);
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3: the grant from idle is the lowest set bit of the sampled requests
  p_pick_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req != '0) |=> (gnt == ($past(req) & (~$past(req) + 1'b1))));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (done & gnt) == '0) |=> (gnt == $past(gnt)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & gnt) != '0) |=> (gnt == '0 && !busy));

  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> (gnt == '0));

  p_busy_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (gnt != '0));
endmodule

bind mem_owner_arbiter mem_owner_arbiter_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .done  (done),
  .gnt   (gnt),
  .busy  (busy)
);

// File: tb/mem_owner_arbiter_test.sv
`timescale 1ns/1ps
module mem_owner_arbiter_test;
  import arb_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req = '0;
  logic [5:0] done = '0;
  logic [5:0] gnt;
  logic       busy;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  mem_owner_arbiter uut (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .done  (done),
    .gnt   (gnt),
    .busy  (busy)
  );

  task automatic check(input string tag, input logic [5:0] exp);
    n_cmp++;
    if (gnt !== exp || busy !== (exp != 0)) begin
      n_bad++;
      $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b",
               tag, gnt, busy, exp, (exp != 0));
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Owner releases; its request and all others drop together.
  task automatic release_owner(input string tag);
    done = gnt;
    req  = '0;
    step();
    done = '0;
    check(tag, 6'b0);
  endtask

  task automatic t_reset();
    step();
    check("R1 in reset", 6'b0);
    req = 6'b111111;
    step();
    check("R1 reset ignores req", 6'b0);
    req = '0;
    rst_n = 1'b1;
    step();
    check("R1 first cycle after reset", 6'b0);
  endtask

  task automatic t_idle();
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8 idle without requests", 6'b0);
    end
  endtask

  task automatic t_single();
    for (int i = 0; i < 6; i++) begin
      req = 6'b1 << i;
      step();
      check("R3 R9 single requester", 6'b1 << i);
      release_owner("R5 single release");
    end
  endtask

  task automatic t_priority();
    logic [5:0] pats [6] = '{6'b111111, 6'b111110, 6'b101100,
                             6'b101000, 6'b110000, 6'b100000};
    logic [5:0] exps [6] = '{6'b000001, 6'b000010, 6'b000100,
                             6'b001000, 6'b010000, 6'b100000};
    for (int k = 0; k < 6; k++) begin
      req = pats[k];
      step();
      check("R3 R2 priority ladder", exps[k]);
      release_owner("R5 priority release");
    end
  endtask

  task automatic t_hold();
    req = 6'b001000;
    step();
    check("R3 write granted", 6'b001000);
    req = 6'b111111;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R4 no preemption", 6'b001000);
    end
    req = '0;
    step();
    check("R4 owner drops req, still held", 6'b001000);
    done = 6'b110111;
    step();
    check("R6 foreign done ignored", 6'b001000);
    done = '0;
    release_owner("R5 owner done releases");
  endtask

  task automatic t_back_to_back();
    req = 6'b110000;
    step();
    check("R3 relaxed gfx wins", 6'b010000);
    done = 6'b010000;
    req  = 6'b100000;
    step();
    done = '0;
    check("R7 one free cycle", 6'b0);
    step();
    check("R7 next owner granted", 6'b100000);
    release_owner("R5 back-to-back release");
  endtask

  task automatic t_withdraw();
    req = 6'b100000;
    step();
    check("R3 relaxed refresh granted", 6'b100000);
    req = 6'b100001;
    step();
    check("R4 urgent pulse does not preempt", 6'b100000);
    req = 6'b100000;
    step();
    release_owner("R5 release after pulse");
    for (int k = 0; k < 2; k++) begin
      step();
      check("R10 withdrawn request not granted", 6'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_priority();
    t_hold();
    t_back_to_back();
    t_withdraw();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule